// File: doc/BRIEF.md
# Clocked Front End for an Asynchronous 32K x 8 Static RAM

This block sits between a synchronous host and an asynchronous static RAM of 32768 bytes. The host asks for one byte at a time. Each request carries an operation bit, a 15-bit address and, for a store, a data byte. The controller turns the request into the RAM's active-LOW select, output-enable and write-enable strobes. It holds the address on the RAM pins, runs the controller's side of the shared data bus, and registers the byte returned by a load. Every analogue timing minimum of the RAM is a nanosecond parameter. Each one is turned into a whole number of clock cycles, with a floor of one cycle, so the same code meets the RAM timing at any clock period.

Each access runs through a fixed sequence of named states:
- **IDLE** waits for a request. The transition IDLE→SETUP takes the request and latches its address, data and operation.
- **SETUP** puts the address on the pins with all strobes HIGH. For a store, the data driver is also turned on here.
- **STROBE** holds select LOW together with write-enable (store) or output-enable (load) for a computed number of cycles.
- From STROBE, a store goes STROBE→HOLD. HOLD keeps the address and data steady with all strobes HIGH, then HOLD→IDLE.
- A load goes STROBE→TURNAROUND. TURNAROUND waits, with the driver off, until the RAM has released the bus, then TURNAROUND→IDLE.

A write is therefore bounded by select and write-enable falling and rising together. Output-enable stays HIGH for the whole store, so the RAM never drives the bus while the controller does.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, select, write-enable and output-enable are HIGH, the data driver is off and `ready` is LOW.
- R2: The strobes only ever take three codes (select, write-enable, output-enable): all HIGH when idle, LOW/LOW/HIGH for a store, and LOW/HIGH/LOW for a load. Write-enable and output-enable are never LOW together, and neither is LOW while select is HIGH.
- R3: The address is taken from `addr` when a request is accepted and appears on the RAM pins at least one cycle before select falls. It stays unchanged while select is LOW and in the cycle after select rises.
- R4: For a store, select and write-enable are LOW for exactly WR_STB cycles. WR_STB is the largest of the cycle counts for the write-enable pulse width, the address-to-write-end time, the select-to-write-end time and the data setup time (6 at the defaults). The data byte is driven and unchanged from SETUP through the whole strobe.
- R5: After a store's strobe rises, select and write-enable stay HIGH for at least one cycle, with address and data still driven. A store occupies at least the write cycle time.
- R6: For a load, select and output-enable are LOW for exactly RD_STB cycles. RD_STB is the largest of the cycle counts for the read cycle, address access, select access and output-enable access times (7 at the defaults). `rdata` is the bus value sampled in the last of those cycles.
- R7: `ready` is HIGH for exactly one cycle per access: the cycle right after the strobe rises. The accept-to-`ready` latency is WR_STB+2 cycles for a store and RD_STB+2 cycles for a load, counted from the cycle in which `req` is presented. During a load's `ready` cycle, `rdata` already holds the new byte.
- R8: After a load, the data driver stays off for at least TURN_CYC cycles after output-enable rises. TURN_CYC is the cycle count of the output float time (3 at the defaults).
- R9: `req` is acted on only in IDLE. A request held HIGH during a busy access starts no further RAM access and changes no memory byte.
- R10: The data driver is on only during a store, and never in a cycle in which output-enable is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-LOW asynchronous reset |
| req | input | 1 | Request strobe, sampled in IDLE |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 15 | Byte address of the request |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Byte returned by the last load |
| ready | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | RAM select, active LOW |
| sram_oe_n | output | 1 | RAM output enable, active LOW |
| sram_we_n | output | 1 | RAM write enable, active LOW |
| sram_addr | output | 15 | RAM address pins |
| sram_dq_o | output | 8 | Byte driven toward the RAM data pins |
| sram_dq_oe | output | 1 | 1 = controller drives the data pins |
| sram_dq_i | input | 8 | Byte seen on the RAM data pins |

## Verification
The bench drives a timing-aware RAM model. The model returns a poison byte until the access time has elapsed, keeps driving for the float time after a load, and checks each write-end against the pulse-width, setup and address-valid minimums. A shortened strobe or turnaround therefore shows up as wrong data, a timing fault or bus contention, not as a silent pass.

Directed cases come first:
- stores and loads at address 0 and address 0x7FFF with all-zeros and all-ones bytes, which separate address and data bit errors;
- a store followed by a load with no idle cycle, and a load followed by a store with no idle cycle, which separate correct turnaround from contention;
- a request held HIGH through a busy store, which separates IDLE-only acceptance from re-triggering.

Seeded random mixed traffic over a small address pool then checks read-after-write against a scoreboard. The pool keeps revisiting the same bytes, so lost or misdirected stores are caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } ctrl_state_e;

    // Whole cycles needed to cover a nanosecond minimum, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int WR_STB   = 6,
    parameter int WR_HOLD  = 1,
    parameter int RD_STB   = 7,
    parameter int TURN_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             done,
    output logic             op_wr,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    ctrl_state_e state, nxt;
    logic        op_wr_q;
    logic        wr_sel;

    // Next-state decode.
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    nxt    = ST_SETUP;
                    accept = 1'b1;
                end
            end
            ST_SETUP:  nxt = ST_STROBE;
            ST_STROBE: if (expired) nxt = op_wr_q ? ST_HOLD : ST_TURN;
            ST_HOLD:   if (expired) nxt = ST_IDLE;
            ST_TURN:   if (expired) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Dwell length of the state being entered.
    always_comb begin
        load     = (nxt != state);
        load_val = '0;
        unique case (nxt)
            ST_STROBE: load_val = op_wr_q ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
            ST_HOLD:   load_val = CNT_W'(WR_HOLD - 1);
            ST_TURN:   load_val = CNT_W'(TURN_CYC - 1);
            default:   load_val = '0;
        endcase
    end

    assign wr_sel = (state == ST_IDLE) ? we : op_wr_q;
    assign done   = (state == ST_STROBE) && expired;
    assign op_wr  = op_wr_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered pin outputs, decoded from the next state so pins are glitch free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dq_oe   <= 1'b0;
        end else begin
            if (accept) op_wr_q <= we;
            ce_n  <= (nxt != ST_STROBE);
            we_n  <= !((nxt == ST_STROBE) && wr_sel);
            oe_n  <= !((nxt == ST_STROBE) && !wr_sel);
            dq_oe <= wr_sel && ((nxt == ST_SETUP) || (nxt == ST_STROBE) || (nxt == ST_HOLD));
        end
    end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              done,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_addr <= '0;
            dq_o      <= '0;
        end else if (accept) begin
            sram_addr <= addr;
            dq_o      <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            ready <= 1'b0;
        end else begin
            ready <= done;
            if (done && !op_wr) rdata <= dq_i;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_WC_NS   = 70,
    parameter int T_AW_NS   = 60,
    parameter int T_SCE_NS  = 60,
    parameter int T_PWE_NS  = 50,
    parameter int T_SD_NS   = 30,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_ACE_NS  = 70,
    parameter int T_DOE_NS  = 35,
    parameter int T_HZ_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int WR_STB = max2(max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                 max2(ns_to_cyc(T_SCE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)));
    localparam int WR_HOLD  = max2(1, ns_to_cyc(T_WC_NS, CLK_NS) - 1 - WR_STB);
    localparam int RD_STB = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                 max2(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
    localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int LONGEST  = max2(max2(WR_STB, RD_STB), max2(WR_HOLD, TURN_CYC));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             done;
    logic             op_wr;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .WR_STB   (WR_STB),
        .WR_HOLD  (WR_HOLD),
        .RD_STB   (RD_STB),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we       (we),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .done     (done),
        .op_wr    (op_wr),
        .ce_n     (sram_ce_n),
        .we_n     (sram_we_n),
        .oe_n     (sram_oe_n),
        .dq_oe    (sram_dq_oe)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .done      (done),
        .op_wr     (op_wr),
        .addr      (addr),
        .wdata     (wdata),
        .dq_i      (sram_dq_i),
        .sram_addr (sram_addr),
        .dq_o      (sram_dq_o),
        .rdata     (rdata),
        .ready     (ready)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int WR_STB   = 6,
    parameter int RD_STB   = 7,
    parameter int TURN_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] a_pins,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe
);

    logic [7:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_lo_cnt <= '0;
            oe_hi_cnt <= 8'hFF;
        end else begin
            we_lo_cnt <= we_n ? 8'd0 : we_lo_cnt + 8'd1;
            oe_lo_cnt <= oe_n ? 8'd0 : oe_lo_cnt + 8'd1;
            if (!oe_n)                oe_hi_cnt <= 8'd0;
            else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 8'd1;
        end
    end

    p_we_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    p_oe_excl_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n));
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> $stable(a_pins));
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> $stable(a_pins));
    p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (dq_oe && $stable(dq_o)));
    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_cnt == 8'(WR_STB)));
    p_write_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (ce_n && dq_oe && $stable(dq_o)));
    p_oe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_lo_cnt == 8'(RD_STB)));
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (oe_hi_cnt >= 8'(TURN_CYC)));
    p_no_drive_on_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

endmodule

bind sram_strobe_ctrl sram_ctrl_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WR_STB   (WR_STB),
    .RD_STB   (RD_STB),
    .TURN_CYC (TURN_CYC)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .ce_n   (sram_ce_n),
    .oe_n   (sram_oe_n),
    .we_n   (sram_we_n),
    .a_pins (sram_addr),
    .dq_o   (sram_dq_o),
    .dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

    localparam int CLK_PERIOD = 10;

    function automatic int e_cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int e_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WR_STB = e_max(e_max(e_cyc(50), e_cyc(60)), e_max(e_cyc(60), e_cyc(30)));
    localparam int E_HOLD   = e_max(1, e_cyc(70) - 1 - E_WR_STB);
    localparam int E_RD_STB = e_max(e_max(e_cyc(70), e_cyc(70)), e_max(e_cyc(70), e_cyc(35)));
    localparam int E_TURN   = e_cyc(25);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [14:0] a_pins;
    logic [7:0]  dq_o;
    logic [7:0]  dq_i = 8'hEE;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
        .sram_we_n(we_n), .sram_addr(a_pins), .sram_dq_o(dq_o),
        .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- timing-aware RAM model ----------------
    logic [7:0] model_mem [int];
    int rd_run = 0, we_run = 0, ce_run = 0, addr_run = 0, dq_run = 0, hz = 0;
    int contention = 0, wr_viol = 0, strobe_bad = 0, ce_falls = 0;
    logic [14:0] last_addr = '0;
    logic [7:0]  last_dq = '0;
    logic        last_ce = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            bit reading;
            reading = !ce_n && !oe_n && we_n;
            if ((ce_n && (!we_n || !oe_n)) || (!we_n && !oe_n)) strobe_bad++;
            if (dq_oe && (reading || hz > 0)) contention++;
            if (last_ce && !ce_n) ce_falls++;
            // write ends when write-enable rises after a LOW run
            if (we_n && we_run > 0) begin
                if (we_run < e_cyc(50) || ce_run < e_cyc(60) ||
                    addr_run < e_cyc(60) || dq_run < e_cyc(30)) wr_viol++;
                model_mem[int'(last_addr)] = last_dq;
            end
            if (reading) begin
                if (rd_run + 1 >= e_cyc(70))
                    dq_i = model_mem.exists(int'(a_pins)) ? model_mem[int'(a_pins)] : 8'h00;
                else
                    dq_i = 8'hEE;
            end else begin
                dq_i = 8'hEE;
            end
            hz       = reading ? e_cyc(25) : ((hz > 0) ? hz - 1 : 0);
            rd_run   = reading ? rd_run + 1 : 0;
            we_run   = we_n ? 0 : we_run + 1;
            ce_run   = ce_n ? 0 : ce_run + 1;
            addr_run = (a_pins == last_addr) ? addr_run + 1 : 1;
            dq_run   = !dq_oe ? 0 : ((dq_o == last_dq) ? dq_run + 1 : 1);
            last_addr = a_pins;
            last_dq   = dq_o;
            last_ce   = ce_n;
        end
    end

    // ---------------- scoreboard and helpers ----------------
    logic [7:0] sb [int];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         input bit keep_req, output logic [7:0] rd, output int lat,
                         output int wl, output int ol);
        req = 1'b1; we = wr; addr = a; wdata = d;
        lat = 0; wl = 0; ol = 0;
        @(negedge clk);
        if (!keep_req) req = 1'b0;
        else addr = a ^ 15'h1234;
        lat = 1;
        while (!ready && lat < 40) begin
            if (!we_n) wl++;
            if (!oe_n) ol++;
            @(negedge clk);
            lat++;
        end
        req = 1'b0;
        rd = rdata;
        repeat (wr ? E_HOLD : E_TURN) @(negedge clk);
        if (wr) sb[int'(a)] = d;
    endtask

    function automatic logic [7:0] sb_get(input logic [14:0] a);
        return sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
    endfunction

    task automatic wr_op(input logic [14:0] a, input logic [7:0] d);
        logic [7:0] rd; int lat, wl, ol;
        do_op(1'b1, a, d, 1'b0, rd, lat, wl, ol);
        chk(lat == E_WR_STB + 2, "R7 store latency", lat, E_WR_STB + 2);
        chk(wl == E_WR_STB && ol == 0, "R4 store strobe cycles", wl * 100 + ol, E_WR_STB * 100);
    endtask

    task automatic rd_op(input logic [14:0] a);
        logic [7:0] rd; int lat, wl, ol;
        do_op(1'b0, a, 8'h00, 1'b0, rd, lat, wl, ol);
        chk(lat == E_RD_STB + 2, "R7 load latency", lat, E_RD_STB + 2);
        chk(ol == E_RD_STB && wl == 0, "R6 load strobe cycles", ol * 100 + wl, E_RD_STB * 100);
        chk(rd == sb_get(a), "R6 load data", int'(rd), int'(sb_get(a)));
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] rd;
        int lat, wl, ol, falls_before;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe && !ready, "R1 in reset",
            {ce_n, we_n, oe_n, dq_oe, ready}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe && !ready, "R1 after reset",
            {ce_n, we_n, oe_n, dq_oe, ready}, 5'b11100);

        // address and data extremes
        wr_op(15'h7FFF, 8'hFF);
        wr_op(15'h0000, 8'h00);
        rd_op(15'h7FFF);
        rd_op(15'h0000);
        wr_op(15'h2AAA, 8'h55);
        rd_op(15'h2AAA);              // store then load, no idle gap
        wr_op(15'h5555, 8'hAA);       // load then store, no idle gap (R8)
        rd_op(15'h5555);

        // R9: req held through a busy store
        falls_before = ce_falls;
        do_op(1'b1, 15'h0100, 8'h3C, 1'b1, rd, lat, wl, ol);
        chk(ce_falls == falls_before + 1, "R9 one access per accepted request",
            ce_falls - falls_before, 1);
        rd_op(15'h0100 ^ 15'h1234);   // the held address must be untouched
        rd_op(15'h0100);

        // constrained random mixed traffic over a small revisited pool
        for (int i = 0; i < 400; i++) begin
            logic [14:0] a;
            a = 15'($urandom % 24) + ((($urandom % 2) != 0) ? 15'h7FE0 : 15'h0000);
            if (($urandom % 2) != 0) wr_op(a, 8'($urandom));
            else                     rd_op(a);
            repeat ($urandom % 3) @(negedge clk);
        end

        chk(strobe_bad == 0, "R2 illegal strobe code seen", strobe_bad, 0);
        chk(wr_viol == 0, "R3 R4 R5 write-end timing", wr_viol, 0);
        chk(contention == 0, "R8 R10 bus contention", contention, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule